// File: doc/BRIEF.md
# Aperture Address Remapping Table

This block remaps client bus addresses that fall inside a fixed aperture onto physical memory, one 4 KiB page at a time. It keeps one table slot per page of the aperture. Each slot holds a valid flag and a physical page frame. Software never sees the table as memory. It programs the table through three words of register space: a control word that turns translation on and off, a selector word that holds the bus address of the page to work on, and a data word that reads or writes the slot chosen by the selector.

Clients present an address on a request strobe. If translation is on, the address lies inside the aperture and the slot for its page is valid, the block returns the physical address: the slot's frame with the page offset of the request. In every other case it returns a fault pulse. Faulting covers addresses outside the aperture, unmapped pages and any access made while translation is off. Both the table lookup and the register read path are registered, so the frame storage maps onto a dual-port block RAM.

Top module: `aperture_remap`

## Requirements
- R1: After reset, translation is off, every slot is invalid, the control word reads 0 and no result pulse appears until a request is made.
- R2: Register offsets are 0x0 for control, 0x4 for selector and 0x8 for entry data. A read returns its data with reg_rvalid exactly one cycle after reg_rd. A write to any other offset changes nothing, and a read of any other offset returns 0.
- R3: The selector reads back the full 32-bit value last written to it. A write to entry data goes to slot (selector - WIN_BASE) >> 12, and is dropped when the selector lies outside the aperture.
- R4: An entry-data word carries the valid flag in bit 31 and the frame in bits 30:12. Bits 11:0 are discarded, so they read back as 0. A slot written with bit 31 clear reads back as 0.
- R5: An entry-data read returns the slot picked by the current selector. It returns 0 when the selector lies outside the aperture.
- R6: A request in the aperture, with translation on and a valid slot, gives cl_vld two cycles later. cl_pa is then {1'b0, frame, request[11:0]}.
- R7: While control bit 0 is 0, every request gives cl_fault two cycles later and never cl_vld.
- R8: A request below WIN_BASE, or at or above WIN_END, gives cl_fault two cycles later.
- R9: Writing 0 to a slot unmaps it, so later requests to that page fault.
- R10: If a table write and a lookup of the same slot fall in the same cycle, the write lands and the lookup returns the slot's previous contents. Lookups made in later cycles see the new value.
- R11: Writing the control word sets the enable to bit 0 of the data, and a read of the control word returns that enable in bit 0.
- R12: Each request gives exactly one one-cycle pulse, either cl_vld or cl_fault, never both, and no pulse appears without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |
| cl_req | input | 1 | Client lookup request |
| cl_addr | input | 32 | Client bus address |
| cl_vld | output | 1 | Translation result valid pulse |
| cl_pa | output | 32 | Translated physical address |
| cl_fault | output | 1 | Fault pulse for a request that cannot be translated |

## Verification
A register read is due one clock edge after reg_rd, and a client result is due two edges after cl_req. The first edge registers the table slot and the request stage, and the second registers the result. The bench drives every input on the falling edge and samples exactly one or two falling edges later, so each check lands in the single cycle the pulse is high. Writes take effect at the edge that captures them, so the model is updated after each write task and before any later lookup. The same-cycle case is driven on one falling edge and checked against the old model value, then against the new one.

// File: rtl/remap_pkg.sv
package remap_pkg;
  localparam int WORD_W     = 32;
  localparam int PAGE_SHIFT = 12;
  localparam int FRAME_W    = WORD_W - 1 - PAGE_SHIFT;
  localparam int REG_AW     = 4;

  localparam logic [REG_AW-1:0] OFS_CTRL = 4'h0;
  localparam logic [REG_AW-1:0] OFS_SEL  = 4'h4;
  localparam logic [REG_AW-1:0] OFS_DATA = 4'h8;

  typedef struct packed {
    logic               valid;
    logic [FRAME_W-1:0] frame;
  } pte_t;
endpackage

// File: rtl/remap_table.sv
module remap_table
  import remap_pkg::*;
#(
  parameter int SLOTS = 64,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  pte_t             wr_pte,
  input  logic [IDX_W-1:0] a_idx,
  output pte_t             a_pte,
  input  logic [IDX_W-1:0] b_idx,
  output pte_t             b_pte
);
  // frame storage without reset so it maps onto a dual-port block RAM
  logic [FRAME_W-1:0] frame_mem [SLOTS];
  logic [FRAME_W-1:0] a_frame_q, b_frame_q;
  logic [SLOTS-1:0]   valid_vec;
  logic               a_valid_q, b_valid_q;

  always_ff @(posedge clk) begin
    if (wr_en) frame_mem[wr_idx] <= wr_pte.frame;
    a_frame_q <= frame_mem[a_idx];
    b_frame_q <= frame_mem[b_idx];
  end

  // valid flags live in flops so reset can clear every slot at once
  for (genvar s = 0; s < SLOTS; s++) begin : g_valid
    always_ff @(posedge clk) begin
      if (rst)                                 valid_vec[s] <= 1'b0;
      else if (wr_en && wr_idx == IDX_W'(s))   valid_vec[s] <= wr_pte.valid;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_valid_q <= 1'b0;
      b_valid_q <= 1'b0;
    end else begin
      a_valid_q <= valid_vec[a_idx];
      b_valid_q <= valid_vec[b_idx];
    end
  end

  assign a_pte = '{valid: a_valid_q, frame: a_frame_q};
  assign b_pte = '{valid: b_valid_q, frame: b_frame_q};
endmodule

// File: rtl/remap_regs.sv
module remap_regs
  import remap_pkg::*;
#(
  parameter logic [WORD_W-1:0] WIN_BASE = 32'h5800_0000,
  parameter logic [WORD_W-1:0] SPAN     = 32'h0004_0000,
  parameter int                IDX_W    = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              reg_rvalid,
  output logic              xlate_en,
  output logic              tw_en,
  output logic [IDX_W-1:0]  tw_idx,
  output pte_t              tw_pte,
  output logic [IDX_W-1:0]  tr_idx,
  input  pte_t              tr_pte
);
  logic              en_q;
  logic [WORD_W-1:0] sel_q;
  logic [WORD_W-1:0] sel_off;
  logic              sel_in;
  logic [IDX_W-1:0]  sel_idx;
  logic [WORD_W-1:0] hold_q;
  logic              from_tab_q;
  logic              sel_in_q;

  // one wrapped subtraction covers both window bounds
  assign sel_off = sel_q - WIN_BASE;
  assign sel_in  = sel_off < SPAN;
  assign sel_idx = sel_in ? sel_off[PAGE_SHIFT +: IDX_W] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      sel_q <= '0;
    end else if (reg_wr) begin
      if (reg_addr == OFS_CTRL) en_q  <= reg_wdata[0];
      if (reg_addr == OFS_SEL)  sel_q <= reg_wdata;
    end
  end

  assign xlate_en = en_q;
  assign tw_en    = reg_wr && (reg_addr == OFS_DATA) && sel_in;
  assign tw_idx   = sel_idx;
  assign tw_pte   = pte_t'(reg_wdata[WORD_W-1:PAGE_SHIFT]);
  assign tr_idx   = sel_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rvalid <= 1'b0;
      hold_q     <= '0;
      from_tab_q <= 1'b0;
      sel_in_q   <= 1'b0;
    end else begin
      reg_rvalid <= reg_rd;
      if (reg_rd) begin
        from_tab_q <= (reg_addr == OFS_DATA);
        sel_in_q   <= sel_in;
        unique case (reg_addr)
          OFS_CTRL: hold_q <= {{(WORD_W-1){1'b0}}, en_q};
          OFS_SEL:  hold_q <= sel_q;
          default:  hold_q <= '0;
        endcase
      end
    end
  end

  always_comb begin
    if (!from_tab_q)                       reg_rdata = hold_q;
    else if (sel_in_q && tr_pte.valid)     reg_rdata = {1'b1, tr_pte.frame, {PAGE_SHIFT{1'b0}}};
    else                                   reg_rdata = '0;
  end

  AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (rst)
    reg_wr && reg_addr == OFS_CTRL |=> xlate_en == $past(reg_wdata[0])); // R11
  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
    reg_rd |=> reg_rvalid); // R2
  AST_NO_STRAY_RVALID: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> !reg_rvalid); // R2
endmodule

// File: rtl/remap_lookup.sv
module remap_lookup
  import remap_pkg::*;
#(
  parameter logic [WORD_W-1:0] WIN_BASE = 32'h5800_0000,
  parameter logic [WORD_W-1:0] SPAN     = 32'h0004_0000,
  parameter int                IDX_W    = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              xlate_en,
  input  logic              cl_req,
  input  logic [WORD_W-1:0] cl_addr,
  output logic [IDX_W-1:0]  tb_idx,
  input  pte_t              tb_pte,
  output logic              cl_vld,
  output logic              cl_fault,
  output logic [WORD_W-1:0] cl_pa
);
  logic [WORD_W-1:0]     off;
  logic                  in_win;
  logic                  req_q, hit_q;
  logic [PAGE_SHIFT-1:0] pofs_q;
  logic                  ok;

  assign off    = cl_addr - WIN_BASE;
  assign in_win = off < SPAN;
  assign tb_idx = in_win ? off[PAGE_SHIFT +: IDX_W] : '0;

  // stage 1: runs alongside the table read
  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
      hit_q <= 1'b0;
    end else begin
      req_q <= cl_req;
      hit_q <= in_win && xlate_en;
    end
    pofs_q <= off[PAGE_SHIFT-1:0];
  end

  assign ok = req_q && hit_q && tb_pte.valid;

  // stage 2: registered result
  always_ff @(posedge clk) begin
    if (rst) begin
      cl_vld   <= 1'b0;
      cl_fault <= 1'b0;
      cl_pa    <= '0;
    end else begin
      cl_vld   <= ok;
      cl_fault <= req_q && !ok;
      cl_pa    <= ok ? {1'b0, tb_pte.frame, pofs_q} : '0;
    end
  end

  AST_DISABLED_FAULT: assert property (@(posedge clk) disable iff (rst)
    cl_req && !xlate_en |=> ##1 cl_fault); // R7
  AST_OUTSIDE_FAULT: assert property (@(posedge clk) disable iff (rst)
    cl_req && !in_win |=> ##1 cl_fault); // R8
  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (rst)
    cl_vld |-> cl_pa[PAGE_SHIFT-1:0] == $past(cl_addr[PAGE_SHIFT-1:0], 2)); // R6
  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (rst)
    !(cl_vld && cl_fault)); // R12
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    (cl_vld || cl_fault) |-> $past(cl_req, 2)); // R12
endmodule

// File: rtl/aperture_remap.sv
module aperture_remap
  import remap_pkg::*;
#(
  parameter logic [31:0] WIN_BASE = 32'h5800_0000,
  parameter logic [31:0] WIN_END  = 32'h5804_0000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        reg_rvalid,
  input  logic        cl_req,
  input  logic [31:0] cl_addr,
  output logic        cl_vld,
  output logic [31:0] cl_pa,
  output logic        cl_fault
);
  localparam logic [WORD_W-1:0] SPAN  = WIN_END - WIN_BASE;
  localparam int                SLOTS = int'(SPAN >> PAGE_SHIFT);
  localparam int                IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic             xlate_en;
  logic             tw_en;
  logic [IDX_W-1:0] tw_idx, tr_idx, tb_idx;
  pte_t             tw_pte, tr_pte, tb_pte;

  remap_regs #(.WIN_BASE(WIN_BASE), .SPAN(SPAN), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst(rst),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .xlate_en(xlate_en),
    .tw_en(tw_en), .tw_idx(tw_idx), .tw_pte(tw_pte),
    .tr_idx(tr_idx), .tr_pte(tr_pte)
  );

  remap_table #(.SLOTS(SLOTS), .IDX_W(IDX_W)) u_table (
    .clk(clk), .rst(rst),
    .wr_en(tw_en), .wr_idx(tw_idx), .wr_pte(tw_pte),
    .a_idx(tr_idx), .a_pte(tr_pte),
    .b_idx(tb_idx), .b_pte(tb_pte)
  );

  remap_lookup #(.WIN_BASE(WIN_BASE), .SPAN(SPAN), .IDX_W(IDX_W)) u_lookup (
    .clk(clk), .rst(rst),
    .xlate_en(xlate_en),
    .cl_req(cl_req), .cl_addr(cl_addr),
    .tb_idx(tb_idx), .tb_pte(tb_pte),
    .cl_vld(cl_vld), .cl_fault(cl_fault), .cl_pa(cl_pa)
  );
endmodule

// File: tb/test_aperture_remap.sv
`timescale 1ns/1ps
module test_aperture_remap;
  localparam logic [31:0] BASE  = 32'h5800_0000;
  localparam logic [31:0] WEND  = 32'h5804_0000;
  localparam logic [31:0] SPAN  = WEND - BASE;
  localparam int          SLOTS = int'(SPAN >> 12);

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_rvalid;
  logic        cl_req = 1'b0;
  logic [31:0] cl_addr = '0;
  logic        cl_vld, cl_fault;
  logic [31:0] cl_pa;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  bit          m_en;
  logic [31:0] m_sel;
  bit          m_valid [SLOTS];
  logic [18:0] m_frame [SLOTS];

  always #2.5 clk = ~clk;

  aperture_remap #(.WIN_BASE(BASE), .WIN_END(WEND)) i_aperture_remap (
    .clk(clk), .rst(rst),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .cl_req(cl_req), .cl_addr(cl_addr),
    .cl_vld(cl_vld), .cl_pa(cl_pa), .cl_fault(cl_fault)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit in_win(input logic [31:0] a);
    logic [31:0] o = a - BASE;
    return o < SPAN;
  endfunction

  function automatic int slot_of(input logic [31:0] a);
    logic [31:0] o = a - BASE;
    return int'(o >> 12);
  endfunction

  function automatic logic [31:0] exp_data();
    int s;
    if (!in_win(m_sel)) return 32'h0;
    s = slot_of(m_sel);
    return m_valid[s] ? {1'b1, m_frame[s], 12'h000} : 32'h0;
  endfunction

  function automatic logic [32:0] exp_look(input logic [31:0] a);
    int s;
    if (!m_en || !in_win(a)) return {1'b0, 32'h0};
    s = slot_of(a);
    if (!m_valid[s]) return {1'b0, 32'h0};
    return {1'b1, 1'b0, m_frame[s], a[11:0]};
  endfunction

  task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    if (a == 4'h0) m_en = d[0];
    if (a == 4'h4) m_sel = d;
    if (a == 4'h8 && in_win(m_sel)) begin
      m_valid[slot_of(m_sel)] = d[31];
      m_frame[slot_of(m_sel)] = d[30:12];
    end
  endtask

  task automatic reg_read(input string tag, input logic [3:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    check({tag, " rvalid (R2)"}, {31'b0, reg_rvalid}, 32'h1);
    check(tag, reg_rdata, exp);
  endtask

  task automatic lookup(input string tag, input logic [31:0] a);
    logic [32:0] e = exp_look(a);
    @(negedge clk);
    cl_req = 1'b1; cl_addr = a;
    @(negedge clk);
    cl_req = 1'b0;
    @(negedge clk);
    check({tag, " vld"},   {31'b0, cl_vld},   {31'b0, e[32]});
    check({tag, " fault"}, {31'b0, cl_fault}, {31'b0, ~e[32]});
    check({tag, " pa"},    cl_pa,             e[31:0]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7013));
    m_en = 1'b0; m_sel = '0;
    for (int i = 0; i < SLOTS; i++) begin m_valid[i] = 1'b0; m_frame[i] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    check("R1 idle vld", {31'b0, cl_vld}, 32'h0);
    check("R1 idle fault", {31'b0, cl_fault}, 32'h0);
    reg_read("R1 ctrl after reset", 4'h0, 32'h0);
    reg_write(4'h4, BASE);
    reg_read("R1 slot0 invalid", 4'h8, 32'h0);
    lookup("R1 disabled after reset", BASE + 32'h10);

    // R11: control read-back
    reg_write(4'h0, 32'hFFFF_FFF1);
    reg_read("R11 ctrl on", 4'h0, 32'h1);

    // R3 selector read-back, R4 entry format
    reg_write(4'h4, BASE + 32'h3123);
    reg_read("R3 selector readback", 4'h4, BASE + 32'h3123);
    reg_write(4'h8, 32'h8123_4FFF);
    reg_read("R4 low bits dropped", 4'h8, 32'h8123_4000);

    // R6: translation
    lookup("R6 hit slot3", BASE + 32'h3ABC);
    check("R6 pa literal", cl_pa, 32'h0123_4ABC);

    // R8: window edges
    lookup("R8 below base", BASE - 32'h4);
    lookup("R8 at end", WEND);
    lookup("R9 last slot unmapped", WEND - 32'h1);
    reg_write(4'h4, WEND - 32'h1000);
    reg_write(4'h8, 32'h8000_7000);
    lookup("R6 last slot mapped", WEND - 32'h1);

    // R4: write with valid clear reads back zero
    reg_write(4'h4, BASE + 32'h2000);
    reg_write(4'h8, 32'h0555_5000);
    reg_read("R4 invalid reads zero", 4'h8, 32'h0);
    lookup("R9 invalid entry faults", BASE + 32'h2004);

    // R7: disable
    reg_write(4'h0, 32'h0);
    lookup("R7 disabled faults", BASE + 32'h3ABC);
    reg_write(4'h0, 32'h1);
    lookup("R7 re-enabled hits", BASE + 32'h3ABC);

    // R9: unmap
    reg_write(4'h4, BASE + 32'h3000);
    reg_write(4'h8, 32'h0);
    lookup("R9 unmapped faults", BASE + 32'h3ABC);

    // R3/R5: selector outside the window, write dropped
    reg_write(4'h4, BASE);
    reg_write(4'h8, 32'h8000_1000);
    reg_write(4'h4, WEND);
    reg_write(4'h8, 32'h8777_7000);
    reg_read("R5 outside selector reads zero", 4'h8, 32'h0);
    lookup("R3 slot0 untouched", BASE + 32'h44);

    // R2: undefined offset
    reg_write(4'hC, 32'h0);
    reg_read("R2 undefined offset", 4'hC, 32'h0);
    reg_read("R2 ctrl unchanged", 4'h0, 32'h1);

    // R10: write and lookup of the same slot in one cycle
    reg_write(4'h4, BASE + 32'h5000);
    reg_write(4'h8, 32'h8000_A000);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 4'h8; reg_wdata = 32'h8000_B000;
    cl_req = 1'b1; cl_addr = BASE + 32'h5008;
    @(negedge clk);
    reg_wr = 1'b0; cl_req = 1'b0;
    @(negedge clk);
    check("R10 same cycle sees old", cl_pa, 32'h0000_A008);
    check("R10 same cycle vld", {31'b0, cl_vld}, 32'h1);
    m_valid[5] = 1'b1; m_frame[5] = 19'h0000B;
    lookup("R10 next lookup sees new", BASE + 32'h5008);

    // randomized mix
    for (int it = 0; it < 600; it++) begin
      int op = $urandom_range(0, 19);
      if (op < 5) begin
        logic [31:0] d = $urandom();
        if ($urandom_range(0, 3) == 0) d[31] = 1'b0; else d[31] = 1'b1;
        reg_write(4'h4, BASE + ($urandom_range(0, SLOTS - 1) << 12) + $urandom_range(0, 4095));
        reg_write(4'h8, d);
      end else if (op == 5) begin
        reg_write(4'h0, {31'b0, ($urandom_range(0, 3) != 0)});
      end else if (op == 6) begin
        reg_read("R5 random data read", 4'h8, exp_data());
      end else begin
        logic [31:0] a = BASE - 32'h2000 + $urandom_range(0, int'(SPAN) + 32'h4000);
        lookup("R12 random lookup", a);
      end
    end

    @(negedge clk);
    check("R12 idle vld", {31'b0, cl_vld}, 32'h0);
    check("R12 idle fault", {31'b0, cl_fault}, 32'h0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule